// File: doc/BRIEF.md
# Rotate and Mask Generator

This block is the datapath of a rotate-then-mask operation. It rotates a 64-bit source left by a programmable amount and builds a contiguous mask from two bit indices. The mask wraps around the word when the start index lies after the end index. It delivers the rotated value, the mask and their bitwise AND. A mode input selects whole-word rotation or half-word rotation. In half-word mode the low 32 bits are copied into both halves before the rotate, and the mask indices refer to the low half.

All bit indices count from the most significant end: index 0 is the MSB of the 64-bit word and index 63 is the LSB. Operands are presented together with a one-cycle `in_valid` strobe. The three results are registered on that clock edge, and `out_valid` marks them during the following cycle. Decode of instruction fields, flag updates and merging under the mask are left to the surrounding pipeline.

Top module: `rotmask_unit`

## Requirements
- R1: Mask indices count from the MSB: index i is bit 63-i of `mask_out`. When `mask_first` < `mask_last`, the mask has ones at indices `mask_first` through `mask_last` inclusive and zeros elsewhere (first 37, last 63 gives 0x0000000007FFFFFF).
- R2: When `mask_first` > `mask_last`, the mask wraps: ones run from `mask_first` to index 63 and from index 0 to `mask_last` (first 47, last 37 gives 0xFFFFFFFFFC01FFFF).
- R3: When `mask_first` = `mask_last`, the mask has exactly one set bit, at that index (index 32 gives 0x0000000080000000).
- R4: With `word_mode` = 0, `rot_out` is `src` rotated left by `rot_amt` modulo 64 (0xDEADBEEF12345678 by 10 gives 0xB6FBBC48D159E37A).
- R5: With `word_mode` = 1, `src[31:0]` is copied into both halves and that word is rotated left, so both halves of `rot_out` are equal. `src[63:32]` has no effect (0xDEADBEEF by 17 gives 0x7DDFBD5B7DDFBD5B).
- R6: With `word_mode` = 1, only the low 5 bits of each mask index are used, and the mask equals the R1 to R3 mask at those indices plus 32 (5 and 15 give 0x0000000007FF0000).
- R7: `result_out` equals `rot_out & mask_out`.
- R8: Results are captured on the rising edge where `in_valid` is 1. `out_valid` is 1 in the cycle after each strobe and 0 in the cycle after a cycle with no strobe.
- R9: While `in_valid` is 0, the three result outputs hold their values regardless of the other inputs.
- R10: A synchronous active-high `rst` clears `rot_out`, `mask_out`, `result_out` and `out_valid` to zero. Reset takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| src | input | 64 | Value to rotate |
| rot_amt | input | 6 | Left rotate amount |
| word_mode | input | 1 | 1 = half-word rotate and half-word mask indices |
| mask_first | input | 6 | Mask start index (MSB = 0) |
| mask_last | input | 6 | Mask end index (MSB = 0) |
| out_valid | output | 1 | Results were captured on the last edge |
| rot_out | output | 64 | Registered rotated value |
| mask_out | output | 64 | Registered mask |
| result_out | output | 64 | Registered rotated value AND mask |

## Verification
All three results and `out_valid` are due at the first rising edge after the strobed operands are applied. Nothing is visible before that edge. The bench drives operands on a falling edge and reads the results on the next falling edge. The latency scenario also samples between the drive and the capturing edge, to confirm that the old value is still present there. Hold and reset checks let several edges pass before sampling, so that a late change would show up.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

   // How the mask generator is built.
   typedef enum logic [0:0] {
      MASK_BY_COMPARE = 1'b0,   // per-bit range comparison
      MASK_BY_SHIFT   = 1'b1    // two shifted thermometers combined
   } mask_style_e;

   // Legal datapath widths: a power of two, at least 4.
   function automatic bit width_ok(int w);
      return (w >= 4) && ((w & (w - 1)) == 0);
   endfunction

endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
   parameter int DATA_W     = 64,
   parameter bit ROT_STAGED = 1'b1,
   localparam int AMT_W     = $clog2(DATA_W),
   localparam int HALF_W    = DATA_W / 2
) (
   input  logic [DATA_W-1:0] src,
   input  logic [AMT_W-1:0]  amt,
   input  logic              half_mode,
   output logic [DATA_W-1:0] rot
);

   logic [DATA_W-1:0] prep;

   // Half mode: the low half is copied into both halves.
   assign prep = half_mode ? {src[HALF_W-1:0], src[HALF_W-1:0]} : src;

   if (ROT_STAGED) begin : g_staged
      logic [AMT_W:0][DATA_W-1:0] stage;
      assign stage[0] = prep;
      for (genvar g = 0; g < AMT_W; g++) begin : g_stage
         localparam int SH = 1 << g;
         assign stage[g+1] = amt[g]
            ? {stage[g][DATA_W-1-SH:0], stage[g][DATA_W-1 -: SH]}
            : stage[g];
      end
      assign rot = stage[AMT_W];
   end else begin : g_flat
      logic [2*DATA_W-1:0] dbl;
      assign dbl = {prep, prep} << amt;
      assign rot = dbl[2*DATA_W-1:DATA_W];
   end

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
   parameter int DATA_W = 64,
   parameter rotmask_pkg::mask_style_e MASK_STYLE = rotmask_pkg::MASK_BY_SHIFT,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  first,
   input  logic [IDX_W-1:0]  last,
   input  logic              half_mode,
   output logic [DATA_W-1:0] mask
);

   logic [IDX_W-1:0] f_eff;
   logic [IDX_W-1:0] l_eff;
   logic             no_wrap;

   // Half mode moves the indices into the low half: adding HALF_W to an
   // index below HALF_W only sets the top index bit.
   assign f_eff   = half_mode ? {1'b1, first[IDX_W-2:0]} : first;
   assign l_eff   = half_mode ? {1'b1, last[IDX_W-2:0]}  : last;
   assign no_wrap = (f_eff <= l_eff);

   if (MASK_STYLE == rotmask_pkg::MASK_BY_COMPARE) begin : g_compare
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
         localparam logic [IDX_W-1:0] POS = IDX_W'(gi);
         logic at_or_after_first;
         logic at_or_before_last;
         assign at_or_after_first = (POS >= f_eff);
         assign at_or_before_last = (POS <= l_eff);
         // Index gi sits at packed position DATA_W-1-gi.
         assign mask[DATA_W-1-gi] = no_wrap
            ? (at_or_after_first & at_or_before_last)
            : (at_or_after_first | at_or_before_last);
      end
   end else begin : g_shift
      localparam logic [DATA_W-1:0] ALL1 = '1;
      logic [DATA_W-1:0] from_first;
      logic [DATA_W-1:0] upto_last;
      // Ones at indices f_eff..DATA_W-1.
      assign from_first = ALL1 >> f_eff;
      // Ones at indices 0..l_eff; two shifts avoid an overflowing l_eff+1.
      assign upto_last  = ~((ALL1 >> l_eff) >> 1);
      assign mask = no_wrap ? (from_first & upto_last) : (from_first | upto_last);
   end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
   parameter int DATA_W     = 64,
   parameter bit ROT_STAGED = 1'b1,
   parameter rotmask_pkg::mask_style_e MASK_STYLE = rotmask_pkg::MASK_BY_SHIFT,
   localparam int IDX_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src,
   input  logic [IDX_W-1:0]  rot_amt,
   input  logic              word_mode,
   input  logic [IDX_W-1:0]  mask_first,
   input  logic [IDX_W-1:0]  mask_last,
   output logic              out_valid,
   output logic [DATA_W-1:0] rot_out,
   output logic [DATA_W-1:0] mask_out,
   output logic [DATA_W-1:0] result_out
);

   if (!rotmask_pkg::width_ok(DATA_W)) begin : g_bad_width
      $error("rotmask_unit: DATA_W must be a power of two and at least 4");
   end

   logic [DATA_W-1:0] rot_c;
   logic [DATA_W-1:0] mask_c;

   rotmask_rotator #(
      .DATA_W     (DATA_W),
      .ROT_STAGED (ROT_STAGED)
   ) u_rot (
      .src       (src),
      .amt       (rot_amt),
      .half_mode (word_mode),
      .rot       (rot_c)
   );

   rotmask_maskgen #(
      .DATA_W     (DATA_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_mask (
      .first     (mask_first),
      .last      (mask_last),
      .half_mode (word_mode),
      .mask      (mask_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         rot_out    <= '0;
         mask_out   <= '0;
         result_out <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            rot_out    <= rot_c;
            mask_out   <= mask_c;
            result_out <= rot_c & mask_c;
         end
      end
   end

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
   parameter int DATA_W  = 64,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int HALF_W = DATA_W / 2
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] src,
   input logic              word_mode,
   input logic [IDX_W-1:0]  mask_first,
   input logic [IDX_W-1:0]  mask_last,
   input logic              out_valid,
   input logic [DATA_W-1:0] rot_out,
   input logic [DATA_W-1:0] mask_out,
   input logic [DATA_W-1:0] result_out
);

   // R3
   single_bit_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (mask_first == mask_last)) |=> ($countones(mask_out) == 1));

   // R4
   rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !word_mode) |=> ($countones(rot_out) == $countones($past(src))));

   // R5
   word_halves_equal_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && word_mode) |=> (rot_out[DATA_W-1:HALF_W] == rot_out[HALF_W-1:0]));

   // R6
   word_mask_low_half_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && word_mode && (mask_first[IDX_W-2:0] <= mask_last[IDX_W-2:0]))
      |=> (mask_out[DATA_W-1:HALF_W] == '0));

   // R7
   result_in_both_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (((result_out & ~rot_out) == '0) && ((result_out & ~mask_out) == '0)));

   // R8
   valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R8
   valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(rot_out) && $stable(mask_out) && $stable(result_out)));

   // R10
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && rot_out == '0 && mask_out == '0 && result_out == '0));

endmodule

bind rotmask_unit rotmask_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .src        (src),
   .word_mode  (word_mode),
   .mask_first (mask_first),
   .mask_last  (mask_last),
   .out_valid  (out_valid),
   .rot_out    (rot_out),
   .mask_out   (mask_out),
   .result_out (result_out)
);

// File: tb/rotmask_unit_test.sv
`timescale 1ns/1ps
module rotmask_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] src = '0;
   logic [5:0]  rot_amt = '0;
   logic        word_mode = 1'b0;
   logic [5:0]  mask_first = '0;
   logic [5:0]  mask_last = '0;
   logic        out_valid;
   logic [63:0] rot_out;
   logic [63:0] mask_out;
   logic [63:0] result_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rotmask_unit uut (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .src        (src),
      .rot_amt    (rot_amt),
      .word_mode  (word_mode),
      .mask_first (mask_first),
      .mask_last  (mask_last),
      .out_valid  (out_valid),
      .rot_out    (rot_out),
      .mask_out   (mask_out),
      .result_out (result_out)
   );

   // Mask built bit by bit from the requirement text.
   function automatic logic [63:0] ref_mask(int f, int l, bit wm);
      logic [63:0] m = '0;
      if (wm) begin
         f = (f % 32) + 32;
         l = (l % 32) + 32;
      end
      for (int i = 0; i < 64; i++)
         m[63-i] = (f <= l) ? (i >= f && i <= l) : (i >= f || i <= l);
      return m;
   endfunction

   function automatic logic [63:0] ref_rot(logic [63:0] v, int n, bit wm);
      logic [63:0] r = '0;
      if (wm) v = {v[31:0], v[31:0]};
      for (int i = 0; i < 64; i++)
         r[(i + n) % 64] = v[i];
      return r;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // Drive one strobe on a falling edge; return on the next falling edge,
   // after the capturing rising edge.
   task automatic apply(logic [63:0] s, int amt, bit wm, int f, int l);
      @(negedge clk);
      src = s; rot_amt = 6'(amt); word_mode = wm;
      mask_first = 6'(f); mask_last = 6'(l); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check_all(string req, logic [63:0] er, logic [63:0] em);
      chk({req, " rot"}, rot_out, er);
      chk({req, " mask"}, mask_out, em);
      chk({req, " R7 result"}, result_out, er & em);
      chk({req, " R8 out_valid"}, 64'(out_valid), 64'd1);
   endtask

   task automatic t_reset_state;
      chk("R10 reset rot", rot_out, '0);
      chk("R10 reset mask", mask_out, '0);
      chk("R10 reset result", result_out, '0);
      chk("R10 reset out_valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_mask_plain;
      apply('1, 0, 1'b0, 37, 63); check_all("R1 37..63", '1, 64'h0000_0000_07FF_FFFF);
      apply('1, 0, 1'b0, 0, 37);  check_all("R1 0..37", '1, 64'hFFFF_FFFF_FC00_0000);
      apply('1, 0, 1'b0, 10, 63); check_all("R1 10..63", '1, 64'h003F_FFFF_FFFF_FFFF);
   endtask

   task automatic t_mask_wrap;
      apply('1, 0, 1'b0, 47, 37); check_all("R2 47>37", '1, 64'hFFFF_FFFF_FC01_FFFF);
      apply('1, 0, 1'b0, 63, 0);  check_all("R2 63>0", '1, 64'h8000_0000_0000_0001);
   endtask

   task automatic t_mask_single;
      apply('1, 0, 1'b0, 32, 32); check_all("R3 32", '1, 64'h0000_0000_8000_0000);
      apply('1, 0, 1'b0, 0, 0);   check_all("R3 0", '1, 64'h8000_0000_0000_0000);
      apply('1, 0, 1'b0, 63, 63); check_all("R3 63", '1, 64'h0000_0000_0000_0001);
   endtask

   task automatic t_rot64;
      apply(64'hDEAD_BEEF_1234_5678, 10, 1'b0, 0, 63);
      check_all("R4 by10", 64'hB6FB_BC48_D159_E37A, '1);
      apply(64'hDEAD_BEEF_1234_5678, 35, 1'b0, 0, 63);
      check_all("R4 by35", 64'h91A2_B3C6_F56D_F778, '1);
      apply(64'hDEAD_BEEF_1234_5678, 58, 1'b0, 0, 63);
      check_all("R4 by58", 64'hE37A_B6FB_BC48_D159, '1);
      apply(64'hDEAD_BEEF_1234_5678, 0, 1'b0, 0, 63);
      check_all("R4 by0", 64'hDEAD_BEEF_1234_5678, '1);
   endtask

   task automatic t_word_rot;
      apply(64'h0000_0000_DEAD_BEEF, 17, 1'b1, 0, 31);
      check_all("R5 by17", 64'h7DDF_BD5B_7DDF_BD5B, 64'h0000_0000_FFFF_FFFF);
      apply(64'h1234_5678_DEAD_BEEF, 10, 1'b1, 0, 31);
      check_all("R5 upper ignored", 64'hB6FB_BF7A_B6FB_BF7A, 64'h0000_0000_FFFF_FFFF);
   endtask

   task automatic t_word_mask;
      apply('1, 0, 1'b1, 5, 15);  check_all("R6 5..15", '1, 64'h0000_0000_07FF_0000);
      apply('1, 0, 1'b1, 15, 5);  check_all("R6 wrap 15>5", '1, 64'hFFFF_FFFF_FC01_FFFF);
      apply('1, 0, 1'b1, 30, 2);  check_all("R6 wrap 30>2", '1, 64'hFFFF_FFFF_E000_0003);
      // index 33 keeps only its low 5 bits, so it acts as 1
      apply('1, 0, 1'b1, 33, 33); check_all("R6 high index bit", '1, 64'h0000_0000_4000_0000);
   endtask

   task automatic t_sweep;
      logic [63:0] s = 64'h0F1E_2D3C_4B5A_6978;
      for (int k = 0; k < 24; k++) begin
         int  a  = (k * 7 + 3) % 64;
         int  f  = (k * 13) % 64;
         int  l  = (k * 29 + 5) % 64;
         bit  wm = k[0];
         apply(s, a, wm, f, l);
         check_all("R7 sweep", ref_rot(s, a, wm), ref_mask(f, l, wm));
         s = {s[62:0], s[63] ^ s[60]} ^ 64'h0000_0000_0000_0F0F;
      end
   endtask

   task automatic t_latency;
      apply(64'h0000_0000_0000_0001, 1, 1'b0, 0, 63);
      @(negedge clk);   // one idle cycle
      src = 64'h0000_0000_0000_0001; rot_amt = 6'd4; word_mode = 1'b0;
      mask_first = 6'd0; mask_last = 6'd63; in_valid = 1'b1;
      #1;
      chk("R8 before edge rot", rot_out, 64'h2);
      chk("R8 before edge out_valid", 64'(out_valid), 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 after edge rot", rot_out, 64'h10);
      chk("R8 after edge out_valid", 64'(out_valid), 64'd1);
      @(negedge clk);
      chk("R8 drops out_valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_hold;
      apply(64'hCAFE_F00D_0000_0001, 8, 1'b0, 8, 55);
      @(negedge clk);
      src = '1; rot_amt = 6'd33; word_mode = 1'b1; mask_first = 6'd3; mask_last = 6'd1;
      repeat (3) @(negedge clk);
      chk("R9 hold rot", rot_out, 64'hFEF0_0D00_0000_01CA);
      chk("R9 hold mask", mask_out, 64'h00FF_FFFF_FFFF_FF00);
      chk("R9 hold result", result_out, 64'h00F0_0D00_0000_0100);
      chk("R9 hold out_valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_reset_mid;
      apply('1, 3, 1'b0, 0, 63);
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;
      t_reset_state();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst = 1'b0;
      t_mask_plain();
      t_mask_wrap();
      t_mask_single();
      t_rot64();
      t_word_rot();
      t_word_mask();
      t_sweep();
      t_latency();
      t_hold();
      t_reset_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule